// File: doc/BRIEF.md
# Not-Recently-Used Way Replacement (4-way)

This block keeps the replacement history of one cache set as one status bit per way. A bit set to 1 says its way has been touched since the history was last cleared. Every access sets the bit of the way it names. When an access would leave every bit at 1, only the accessed way keeps its bit and all the other bits drop to 0. The history therefore never saturates.

On a miss the block names the way to evict. This is the first way whose bit is 0, reported both as a binary index and as a one-hot vector. The fill of that way counts as an access in the same cycle. In fixed mode the search for a clear bit begins at way 0. In rotating mode it begins at the value of a small counter that steps once per miss, so the low-numbered ways are not always picked first. A load port lets a surrounding per-set array write a stored history into the block before the set is used.

Top module: `nru_replace`

## Requirements
- R1: After reset the history vector is 0000 and the rotation counter is 0, so the reported victim is way 0 (one-hot 0001).
- R2: An access strobe (accValid=1) with way w sets bit w of the history at the next clock edge and leaves the other bits unchanged, provided the result is not all ones.
- R3: If setting bit w would make all bits 1, the history at the next edge is exactly the one-hot vector of w.
- R4: With rotEn=0 the victim is the lowest-numbered way whose history bit is 0.
- R5: victimOneHot always has exactly one bit set, at position victimIdx (bit i stands for way i).
- R6: With rotEn=1 the search starts at the way given by the rotation counter and proceeds upward, wrapping from way 3 to way 0. The victim is the first way found with a 0 bit.
- R7: The rotation counter is 2 bits wide. It advances by one, wrapping from 3 to 0, in each cycle where a miss is taken, whatever the mode. It holds in all other cycles.
- R8: When missReq=1 and no load is requested, the way shown on victimIdx in that cycle is treated as accessed at the next edge, under the rules of R2 and R3. A simultaneous access strobe is ignored.
- R9: When loadValid=1, the history takes loadBits at the next edge. Miss and access requests in that cycle are ignored, and the counter does not advance.
- R10: If the history is all ones, which only a load can produce, the victim is the current search start: way 0 in fixed mode, or the counter value in rotating mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rotEn | input | 1 | 1 selects the rotating search start, 0 starts at way 0 |
| accValid | input | 1 | Access strobe for the way on accWay |
| accWay | input | 2 | Way being accessed |
| missReq | input | 1 | Miss: fill the current victim and update the history |
| loadValid | input | 1 | Write loadBits into the history |
| loadBits | input | 4 | History value to load, bit i for way i |
| mruBits | output | 4 | Current history vector, bit i for way i |
| victimIdx | output | 2 | Way chosen for eviction, binary |
| victimOneHot | output | 4 | Way chosen for eviction, one-hot |

## Verification
Several properties are checked on every cycle. The one-hot victim must agree with the binary index and must point at a clear bit whenever one exists. An access must leave its bit set and the vector not full. A load must land exactly. The counter must step on each miss. Only the bench scenarios can show the search order itself: the lowest clear way in fixed mode, the wrapped scan from the counter in rotating mode, miss-over-access priority, and the fall-back pick when a loaded vector is full. These are checked against a behavioural model on every clock, in both modes.

// File: rtl/nru_pkg.sv
package nru_pkg;
  typedef struct packed {
    logic doLoad;
    logic doMiss;
    logic doAccess;
  } nruStrobe_t;
endpackage

// File: rtl/nru_ctrl.sv
module nru_ctrl
  import nru_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accValid,
  input  logic       missReq,
  input  logic       loadValid,
  output nruStrobe_t strobe
);
  // priority: load, then miss, then plain access
  always_comb begin
    strobe.doLoad   = loadValid;
    strobe.doMiss   = missReq & ~loadValid;
    strobe.doAccess = accValid & ~missReq & ~loadValid;
  end

  // R9 / R8: at most one update source acts per cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobe.doLoad, strobe.doMiss, strobe.doAccess}) <= 1);

  // R8: a miss suppresses a concurrent access
  a_r8_miss_masks_access: assert property (@(posedge clk) disable iff (!rst_n)
    (missReq && accValid) |-> !strobe.doAccess);
endmodule

// File: rtl/nru_datapath.sv
module nru_datapath
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int IW = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  nruStrobe_t          strobe,
  input  logic                rotEn,
  input  logic [IW-1:0]       accWay,
  input  logic [NUM_WAYS-1:0] loadBits,
  output logic [NUM_WAYS-1:0] mruBits,
  output logic [IW-1:0]       victimIdx,
  output logic [NUM_WAYS-1:0] victimOneHot
);
  logic [NUM_WAYS-1:0] mruQ;
  logic [IW-1:0]       rotQ;
  logic [IW-1:0]       startIdx;
  logic [IW-1:0]       scanIdx;
  logic [IW-1:0]       vIdx;
  logic                found;
  logic [IW-1:0]       updWay;
  logic [NUM_WAYS-1:0] wayHot;
  logic [NUM_WAYS-1:0] setVec;
  logic [NUM_WAYS-1:0] nextMru;

  assign startIdx = rotEn ? rotQ : '0;

  // wrapped scan for the first clear bit from startIdx
  always_comb begin
    found   = 1'b0;
    vIdx    = startIdx;
    scanIdx = startIdx;
    for (int k = 0; k < NUM_WAYS; k++) begin
      scanIdx = startIdx + IW'(k);
      if (!found && !mruQ[scanIdx]) begin
        vIdx  = scanIdx;
        found = 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_hot
      assign victimOneHot[g] = (vIdx == IW'(g));
      assign wayHot[g]       = (updWay == IW'(g));
    end
  endgenerate

  assign updWay  = strobe.doMiss ? vIdx : accWay;
  assign setVec  = mruQ | wayHot;
  assign nextMru = (&setVec) ? wayHot : setVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mruQ <= '0;
      rotQ <= '0;
    end else begin
      if (strobe.doLoad)
        mruQ <= loadBits;
      else if (strobe.doMiss || strobe.doAccess)
        mruQ <= nextMru;
      if (strobe.doMiss)
        rotQ <= rotQ + 1'b1;
    end
  end

  assign mruBits   = mruQ;
  assign victimIdx = vIdx;

  // R2: the accessed way is marked afterwards
  a_r2_access_marks: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doAccess |=> mruQ[$past(accWay)]);

  // R3: an update never leaves the vector saturated
  a_r3_no_saturation: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doAccess || strobe.doMiss) |=> (mruQ != '1));

  // R4 / R6: the victim points at a clear bit when one exists
  a_r4_victim_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mruQ != '1) |-> !mruQ[victimIdx]);

  // R5: one-hot form agrees with binary form
  a_r5_onehot_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(victimOneHot) == 1) && victimOneHot[victimIdx]);

  // R7: counter steps on a miss and holds otherwise
  a_r7_rot_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doMiss |=> (rotQ == IW'($past(rotQ) + 1'b1)));
  a_r7_rot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.doMiss |=> $stable(rotQ));

  // R9: a load lands exactly
  a_r9_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doLoad |=> (mruQ == $past(loadBits)));
endmodule

// File: rtl/nru_replace.sv
module nru_replace
  import nru_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int IW = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rotEn,
  input  logic                accValid,
  input  logic [IW-1:0]       accWay,
  input  logic                missReq,
  input  logic                loadValid,
  input  logic [NUM_WAYS-1:0] loadBits,
  output logic [NUM_WAYS-1:0] mruBits,
  output logic [IW-1:0]       victimIdx,
  output logic [NUM_WAYS-1:0] victimOneHot
);
  nruStrobe_t strobe;

  nru_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accValid  (accValid),
    .missReq   (missReq),
    .loadValid (loadValid),
    .strobe    (strobe)
  );

  nru_datapath #(.NUM_WAYS(NUM_WAYS)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .rotEn        (rotEn),
    .accWay       (accWay),
    .loadBits     (loadBits),
    .mruBits      (mruBits),
    .victimIdx    (victimIdx),
    .victimOneHot (victimOneHot)
  );
endmodule

// File: tb/sim_nru_replace.sv
`timescale 1ns/1ps
module sim_nru_replace;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rotEn = 1'b0;
  logic       accValid = 1'b0;
  logic [1:0] accWay = '0;
  logic       missReq = 1'b0;
  logic       loadValid = 1'b0;
  logic [3:0] loadBits = '0;
  logic [3:0] mruBits;
  logic [1:0] victimIdx;
  logic [3:0] victimOneHot;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int mdlBits = 0;
  int mdlRot  = 0;

  always #5 clk = ~clk;

  nru_replace u0 (
    .clk(clk), .rst_n(rst_n), .rotEn(rotEn), .accValid(accValid),
    .accWay(accWay), .missReq(missReq), .loadValid(loadValid),
    .loadBits(loadBits), .mruBits(mruBits), .victimIdx(victimIdx),
    .victimOneHot(victimOneHot)
  );

  function automatic int mdlVictim(int bits, int rot, bit rmode);
    int st = rmode ? rot : 0;
    for (int k = 0; k < 4; k++) begin
      int w = (st + k) % 4;
      if (((bits >> w) & 1) == 0) return w;
    end
    return st;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, verify victim now and history after the edge
  task automatic step(bit a, int w, bit m, bit l, int lb);
    int v;
    int nb;
    string vt;
    string ut;
    accValid = a; accWay = 2'(w); missReq = m; loadValid = l; loadBits = 4'(lb);
    #1;
    v  = mdlVictim(mdlBits, mdlRot, rotEn);
    vt = (mdlBits == 15) ? "R10" : (rotEn ? "R6" : "R4");
    check(vt, victimIdx, v);
    check("R5", victimOneHot, 1 << v);
    nb = mdlBits;
    ut = "R7";
    if (l) begin
      nb = lb; ut = "R9";
    end else if (m || a) begin
      int uw = m ? v : w;
      nb = mdlBits | (1 << uw);
      if (nb == 15) begin nb = 1 << uw; ut = "R3"; end
      else ut = m ? "R8" : "R2";
    end
    if (m && !l) mdlRot = (mdlRot + 1) % 4;
    mdlBits = nb;
    @(posedge clk);
    #1;
    check(ut, mruBits, mdlBits);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", mruBits, 0);
    check("R1", victimIdx, 0);
    check("R1", victimOneHot, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 plain accesses, R3 saturation clear
    step(1, 2, 0, 0, 0);
    check("R2", mruBits, 4'b0100);
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    check("R4", victimIdx, 3);
    step(1, 3, 0, 0, 0);
    check("R3", mruBits, 4'b1000);
    // R8 miss fills victim, access ignored
    step(1, 3, 1, 0, 0);
    check("R8", mruBits, 4'b1001);
    // R9 load wins over miss
    step(1, 1, 1, 1, 4'b0110);
    check("R9", mruBits, 4'b0110);
    // R10 full vector by load
    step(0, 0, 0, 1, 4'b1111);
    check("R10", victimIdx, 0);
    // R6 / R7 rotating start: counter is 1 after one miss
    rotEn = 1'b1;
    step(0, 0, 0, 1, 4'b0000);
    #1 check("R7", victimIdx, mdlRot);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    check("R7", victimIdx, (mdlRot + 1) % 4 == victimIdx ? victimIdx : mdlVictim(mdlBits, mdlRot, 1));
    // mixed random traffic in both modes
    for (int i = 0; i < 600; i++) begin
      if (i % 150 == 0) rotEn = ~rotEn;
      step($urandom_range(0, 1), $urandom_range(0, 3), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 15) == 0), $urandom_range(0, 15));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule